// File: doc/BRIEF.md
# Interrupt Sequencer with Return Stack

This block decides when a small processor core leaves its instruction stream to service an interrupt, and it keeps the return addresses for subroutine calls and interrupts. It handles two maskable sources: a timer overflow and a port edge event. Each source has a request flag and an enable flag. Software reaches these flags through a 4-bit register bus, and hardware event pulses set the request flags. A source counts as pending when its request and its enable are both set. The core must then retire two more instructions before the block takes the vector. If the pending condition goes away during that window, the interrupt is cancelled.

When the block takes an interrupt, it pushes the current program counter and carry flag as one entry onto a shared last-in first-out stack. It also clears every enable bit, loads the vector address onto its new-PC output and raises a one-cycle taken pulse. Call strobes push onto the same stack. Return strobes pop it, and a return-type input selects whether the carry flag is restored along with the PC. Instruction decode and the ALU sit outside the block. The core drives the retire, call and return strobes and supplies the return address on the PC input.

Top module: `irq_seq_top`

## Requirements
- R1: After a synchronous reset, all enable and request flags read 0, and the outputs vec_take, pc_load and cy_load are 0.
- R2: reg_sel=0 selects the enable register and reg_sel=1 selects the request register. Bit 2 belongs to the timer and bit 0 to the port. Bits 3 and 1 always read 0. A write takes effect at the clock edge. tmr_evt sets request bit 2 and port_evt sets request bit 0 at the same edge, and an event wins over a write that clears the same bit.
- R3: An interrupt is taken only when some source has both its enable bit and its request bit set.
- R4: Retires are counted only once the pending condition has held for at least one cycle. The vector is taken at the clock edge after the second counted retire, so vec_take and pc_load are high in the cycle that follows that edge, and never earlier.
- R5: If the pending condition drops at any point before the vector is taken, the interrupt is cancelled and the retire count restarts from zero.
- R6: The timer vector is 0x002 and the port vector is 0x004. When both sources are pending and enabled, the timer vector is taken.
- R7: Taking an interrupt clears all enable bits and leaves the request flags unchanged.
- R8: A taken interrupt or a call pushes {cy_in, pc_in} as one 13-bit entry, with carry in the top bit. A return with ret_carry=1 loads the popped PC onto pc_next (pc_load=1) and the popped carry onto cy_next (cy_load=1).
- R9: A return with ret_carry=0 loads the popped PC and keeps cy_load at 0.
- R10: The stack holds DEPTH entries and is LIFO. A push onto a full stack discards the oldest entry.
- R11: Popping past the last stored entry returns the bottom entry again, and no underflow indication is given.
- R12: While call_stb or ret_stb is high, a due interrupt waits. It is taken at the first edge without such a strobe, as long as it is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = enable register, 1 = request register |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Selected register contents |
| tmr_evt | input | 1 | Timer overflow pulse, sets timer request |
| port_evt | input | 1 | Port edge pulse, sets port request |
| retire | input | 1 | One instruction retired this cycle |
| call_stb | input | 1 | Call: push return address |
| ret_stb | input | 1 | Return: pop the stack |
| ret_carry | input | 1 | Return restores carry when 1 |
| pc_in | input | 12 | Address to push |
| cy_in | input | 1 | Carry flag to push |
| vec_take | output | 1 | One-cycle pulse when an interrupt is taken |
| pc_load | output | 1 | pc_next is valid this cycle |
| pc_next | output | 12 | Vector or popped return address |
| cy_load | output | 1 | cy_next is valid this cycle |
| cy_next | output | 1 | Restored carry flag |

## Verification
The bench builds the block with its default DEPTH of 4 and RETIRE_DLY of 2. At a depth of 4, a fifth push and the drop of the oldest entry that follows take only a few cycles to reach, as does the repeated bottom value on underflow. The two-retire window is short enough that random register writes, which clear enables or requests, often land inside it. This regularly exercises cancellation and the timer-over-port priority. Strobes that fall on the edge where an interrupt is due test the deferral rule.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    localparam int PC_W    = 12;
    localparam int REG_W   = 4;
    localparam int TMR_BIT = 2;
    localparam int PRT_BIT = 0;
    localparam logic [REG_W-1:0] SRC_MASK = REG_W'((1 << TMR_BIT) | (1 << PRT_BIT));
    localparam logic [PC_W-1:0]  VEC_TMR  = PC_W'(12'h002);
    localparam logic [PC_W-1:0]  VEC_PRT  = PC_W'(12'h004);

    typedef struct packed {
        logic            cy;
        logic [PC_W-1:0] pc;
    } stk_ent_t;

    // Timer has priority over port.
    function automatic logic [PC_W-1:0] pick_vector(input logic [REG_W-1:0] act);
        return act[TMR_BIT] ? VEC_TMR : VEC_PRT;
    endfunction
endpackage

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
    import irq_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    input  logic             tmr_evt,
    input  logic             port_evt,
    input  logic             clr_en,
    output logic [REG_W-1:0] en_o,
    output logic [REG_W-1:0] req_o,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] hw_set;

    always_comb begin
        hw_set          = '0;
        hw_set[TMR_BIT] = tmr_evt;
        hw_set[PRT_BIT] = port_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o  <= '0;
            req_o <= '0;
        end else begin
            if (clr_en)
                en_o <= '0;
            else if (wr && !sel)
                en_o <= wdata & SRC_MASK;
            req_o <= ((wr && sel) ? (wdata & SRC_MASK) : req_o) | hw_set;
        end
    end

    assign rdata = sel ? req_o : en_o;
endmodule

// File: rtl/irq_take_ctl.sv
module irq_take_ctl
    import irq_seq_pkg::*;
#(
    parameter int RETIRE_DLY = 2,
    localparam int CNT_W = $clog2(RETIRE_DLY + 1)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] en,
    input  logic [REG_W-1:0] req,
    input  logic             retire,
    input  logic             busy,
    output logic             take_o,
    output logic             pend_o,
    output logic [PC_W-1:0]  vec_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(RETIRE_DLY);

    logic [REG_W-1:0] act;

    assign act    = en & req & SRC_MASK;
    assign pend_o = |act;
    assign take_o = pend_o && (cnt_o == CNT_DONE) && !busy;
    assign vec_o  = pick_vector(act);

    always_ff @(posedge clk) begin
        if (rst || take_o || !pend_o)
            cnt_o <= '0;
        else if (retire && cnt_o != CNT_DONE)
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import irq_seq_pkg::*;
#(
    parameter int DEPTH = 4
)(
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  logic     pop,
    input  stk_ent_t din,
    output stk_ent_t top_o
);
    stk_ent_t ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        stk_ent_t from_above, from_below;
        if (i == 0) begin : g_first
            assign from_above = din;
        end else begin : g_mid
            assign from_above = ent[i-1];
        end
        if (i == DEPTH - 1) begin : g_last
            assign from_below = ent[i];
        end else begin : g_upper
            assign from_below = ent[i+1];
        end
        always_ff @(posedge clk) begin
            if (rst)
                ent[i] <= '0;
            else if (pop)
                ent[i] <= from_below;
            else if (push)
                ent[i] <= from_above;
        end
    end

    assign top_o = ent[0];
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
    import irq_seq_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int RETIRE_DLY = 2,
    localparam int CNT_W = $clog2(RETIRE_DLY + 1)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             tmr_evt,
    input  logic             port_evt,
    input  logic             retire,
    input  logic             call_stb,
    input  logic             ret_stb,
    input  logic             ret_carry,
    input  logic [PC_W-1:0]  pc_in,
    input  logic             cy_in,
    output logic             vec_take,
    output logic             pc_load,
    output logic [PC_W-1:0]  pc_next,
    output logic             cy_load,
    output logic             cy_next
);
    logic [REG_W-1:0] en_q, req_q;
    logic             take, ctl_pend;
    logic [PC_W-1:0]  vec;
    logic [CNT_W-1:0] ctl_cnt;
    stk_ent_t         top, push_ent;
    logic             do_push;

    irq_flag_regs u_flags (
        .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .tmr_evt(tmr_evt), .port_evt(port_evt), .clr_en(take),
        .en_o(en_q), .req_o(req_q), .rdata(reg_rdata)
    );

    irq_take_ctl #(.RETIRE_DLY(RETIRE_DLY)) u_ctl (
        .clk(clk), .rst(rst), .en(en_q), .req(req_q), .retire(retire),
        .busy(call_stb | ret_stb), .take_o(take), .pend_o(ctl_pend),
        .vec_o(vec), .cnt_o(ctl_cnt)
    );

    assign push_ent = '{cy: cy_in, pc: pc_in};
    assign do_push  = take | (call_stb & ~ret_stb);

    ret_stack #(.DEPTH(DEPTH)) u_stk (
        .clk(clk), .rst(rst), .push(do_push), .pop(ret_stb),
        .din(push_ent), .top_o(top)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_take <= 1'b0;
            pc_load  <= 1'b0;
            pc_next  <= '0;
            cy_load  <= 1'b0;
            cy_next  <= 1'b0;
        end else begin
            vec_take <= take;
            pc_load  <= take | ret_stb;
            pc_next  <= take ? vec : (ret_stb ? top.pc : '0);
            cy_load  <= ret_stb & ret_carry;
            cy_next  <= (ret_stb & ret_carry) ? top.cy : 1'b0;
        end
    end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk
    import irq_seq_pkg::*;
#(
    parameter int CNT_W = 2,
    parameter int RETIRE_DLY = 2
)(
    input logic             clk,
    input logic             rst,
    input logic             vec_take,
    input logic             cy_load,
    input logic [PC_W-1:0]  pc_next,
    input logic [REG_W-1:0] en,
    input logic [CNT_W-1:0] cnt,
    input logic             pend,
    input logic             call_stb,
    input logic             ret_stb
);
    // R7
    a_r7_enables_cleared: assert property (@(posedge clk) disable iff (rst)
        vec_take |-> (en == '0));
    // R3
    a_r3_take_needs_pending: assert property (@(posedge clk) disable iff (rst)
        vec_take |-> $past(pend));
    // R4
    a_r4_two_retires: assert property (@(posedge clk) disable iff (rst)
        vec_take |-> ($past(cnt) == CNT_W'(RETIRE_DLY)));
    // R6
    a_r6_vector_value: assert property (@(posedge clk) disable iff (rst)
        vec_take |-> (pc_next == VEC_TMR || pc_next == VEC_PRT));
    // R12
    a_r12_defer_strobe: assert property (@(posedge clk) disable iff (rst)
        vec_take |-> (!$past(call_stb) && !$past(ret_stb)));
    // R9
    a_r9_carry_only_on_return: assert property (@(posedge clk) disable iff (rst)
        cy_load |-> !vec_take);
endmodule

bind irq_seq_top irq_seq_chk #(.CNT_W(CNT_W), .RETIRE_DLY(RETIRE_DLY)) chk_i (
    .clk(clk), .rst(rst), .vec_take(vec_take), .cy_load(cy_load),
    .pc_next(pc_next), .en(en_q), .cnt(ctl_cnt), .pend(ctl_pend),
    .call_stb(call_stb), .ret_stb(ret_stb)
);

// File: tb/irq_seq_tb.sv
module irq_seq_top_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 0, reg_sel = 0, tmr_evt = 0, port_evt = 0, retire = 0;
    logic call_stb = 0, ret_stb = 0, ret_carry = 0, cy_in = 0;
    logic [3:0]  reg_wdata = 0, reg_rdata;
    logic [11:0] pc_in = 0, pc_next;
    logic vec_take, pc_load, cy_load, cy_next;

    int checks = 0, errors = 0, cycles = 0;

    // bench reference state
    logic [3:0]  m_en, m_req;
    int          m_cnt;
    logic [12:0] m_stk [4];
    logic        e_vt, e_pl, e_cl, e_cy;
    logic [11:0] e_pc;

    always #4 clk = ~clk;

    irq_seq_top dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_evt(tmr_evt),
        .port_evt(port_evt), .retire(retire), .call_stb(call_stb),
        .ret_stb(ret_stb), .ret_carry(ret_carry), .pc_in(pc_in), .cy_in(cy_in),
        .vec_take(vec_take), .pc_load(pc_load), .pc_next(pc_next),
        .cy_load(cy_load), .cy_next(cy_next)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] rd_exp(input logic sel);
        return sel ? m_req : m_en;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1; reg_wr = 0; tmr_evt = 0; port_evt = 0; retire = 0;
        call_stb = 0; ret_stb = 0; ret_carry = 0;
        @(posedge clk); @(negedge clk); rst = 0;
        m_en = 0; m_req = 0; m_cnt = 0;
        for (int i = 0; i < 4; i++) m_stk[i] = '0;
        // R1 reset state
        chk("R1 vec_take", 16'(vec_take), 0);
        chk("R1 pc_load", 16'(pc_load), 0);
        chk("R1 cy_load", 16'(cy_load), 0);
        reg_sel = 0; #1 chk("R1 enable reg", 16'(reg_rdata), 0);
        reg_sel = 1; #1 chk("R1 request reg", 16'(reg_rdata), 0);
    endtask

    task automatic cyc(input bit rt, input bit wr, input bit sel, input logic [3:0] wd,
                       input bit te, input bit pe, input bit ca, input bit re,
                       input bit rc, input logic [11:0] pc, input bit cy);
        logic pend, take;
        logic [3:0] act, hw;
        logic [12:0] top;
        @(negedge clk);
        retire = rt; reg_wr = wr; reg_sel = sel; reg_wdata = wd; tmr_evt = te;
        port_evt = pe; call_stb = ca; ret_stb = re; ret_carry = rc; pc_in = pc; cy_in = cy;
        @(posedge clk);
        act  = m_en & m_req & 4'b0101;
        pend = |act;
        take = pend && m_cnt == 2 && !ca && !re;
        top  = m_stk[0];
        e_vt = take;
        e_pl = take | re;
        e_pc = take ? (act[2] ? 12'h002 : 12'h004) : top[11:0];
        e_cl = re & rc;
        e_cy = top[12];
        if (take || !pend) m_cnt = 0;
        else if (rt && m_cnt < 2) m_cnt++;
        if (take) m_en = 0;
        else if (wr && !sel) m_en = wd & 4'b0101;
        hw = {1'b0, te, 1'b0, pe};
        m_req = ((wr && sel) ? (wd & 4'b0101) : m_req) | hw;
        if (re) begin
            for (int i = 0; i < 3; i++) m_stk[i] = m_stk[i+1];
        end else if (take || ca) begin
            for (int i = 3; i > 0; i--) m_stk[i] = m_stk[i-1];
            m_stk[0] = {cy, pc};
        end
        #1;
        chk("R4 vec_take", 16'(vec_take), 16'(e_vt));
        chk("R8 pc_load", 16'(pc_load), 16'(e_pl));
        if (e_pl) chk("R6/R8 pc_next", 16'(pc_next), 16'(e_pc));
        chk("R9 cy_load", 16'(cy_load), 16'(e_cl));
        if (e_cl) chk("R8 cy_next", 16'(cy_next), 16'(e_cy));
        chk("R2 reg_rdata", 16'(reg_rdata), 16'(rd_exp(sel)));
    endtask

    task automatic idle(input bit rt);
        cyc(rt, 0, 0, 0, 0, 0, 0, 0, 0, 12'h0, 0);
    endtask

    initial begin
        while (cycles < 200000) begin
            @(posedge clk); cycles++;
        end
        errors++;
        $display("FAIL watchdog actual=%0d expected<200000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();

        // R2: upper/odd bits read 0, event beats clearing write
        cyc(0, 1, 0, 4'hF, 0, 0, 0, 0, 0, 0, 0);
        chk("R2 enable bits", 16'(reg_rdata), 16'h5);
        cyc(0, 1, 1, 4'h0, 1, 0, 0, 0, 0, 0, 0);
        chk("R2 event wins", 16'(reg_rdata), 16'h4);
        // R4: timer pending now; two retires then take
        idle(1);
        chk("R4 no take after one retire", 16'(vec_take), 0);
        idle(1);
        chk("R4 no take after two retires", 16'(vec_take), 0);
        idle(0);
        chk("R4 take after two retires", 16'(vec_take), 1);
        chk("R6 timer vector", 16'(pc_next), 16'h002);
        // R7: enables cleared, request kept
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R7 enables cleared", 16'(reg_rdata), 0);
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R7 request kept", 16'(reg_rdata), 16'h4);

        // R5: cancellation by clearing enable during window
        do_reset();
        cyc(0, 1, 1, 4'h1, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 4'h1, 0, 0, 0, 0, 0, 0, 0);
        idle(1);
        cyc(1, 1, 0, 4'h0, 0, 0, 0, 0, 0, 0, 0);
        idle(0); idle(0);
        chk("R5 cancelled", 16'(vec_take), 0);
        // R3: request alone does not fire
        idle(1); idle(1); idle(1);
        chk("R3 no enable no take", 16'(vec_take), 0);

        // R6 priority + R12 deferral
        do_reset();
        cyc(0, 1, 1, 4'h5, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 4'h5, 0, 0, 0, 0, 0, 0, 0);
        idle(1); idle(1);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 12'h123, 1);
        chk("R12 deferred under call", 16'(vec_take), 0);
        idle(0);
        chk("R12 taken after strobe", 16'(vec_take), 1);
        chk("R6 timer priority", 16'(pc_next), 16'h002);

        // R10/R11: five pushes, then pops
        do_reset();
        for (int i = 1; i <= 5; i++)
            cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 12'(i * 16'h111), i[0]);
        for (int i = 5; i >= 1; i--) begin
            cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
            chk("R10 LIFO pc", 16'(pc_next), 16'((i < 2 ? 2 : i) * 16'h111));
            chk("R10 LIFO carry", 16'(cy_next), 16'((i < 2 ? 2 : i) % 2));
        end
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        chk("R11 underflow repeats bottom", 16'(pc_next), 16'h222);
        chk("R9 plain return no carry", 16'(cy_load), 0);

        // random phase
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            int r;
            bit ca, re;
            r  = int'($urandom_range(0, 99));
            ca = (r < 6);
            re = (r >= 6 && r < 12);
            cyc($urandom_range(0, 99) < 70, $urandom_range(0, 99) < 12,
                1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
                $urandom_range(0, 99) < 6, $urandom_range(0, 99) < 6,
                ca, re, 1'($urandom_range(0, 1)), 12'($urandom_range(0, 4095)),
                1'($urandom_range(0, 1)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule